// File: doc/BRIEF.md
# Burst Column Sequencer with Clock Suspend

This block is the column side of a single-data-rate synchronous DRAM. It takes READ, WRITE and NOP commands, each with a bank and a starting column. For every beat of the burst it generates the column address. It stores write words in a small internal array and returns read words after a selectable CAS latency. The burst length, the address ordering, the CAS latency and a single-write option come in on static mode inputs. The burst length and the ordering are captured with each command.

A clock-enable input lets the attached controller stall a burst. When the enable is sampled low on a rising edge, the next internal edge is suppressed. On a suppressed edge the beat counter and the latency pipeline hold their state, and any command or write data presented there is discarded. While the burst is stalled, the read bus keeps its last word and the valid flag stays low. When the enable is high again, the burst resumes at the column where it stopped, so read data arrives late by exactly the number of suppressed edges.

Top module: `col_burst_engine`

## Requirements
- R1: When `cke` is sampled low on a rising edge, the next rising edge is suppressed. A command, address or `wrData` present at a suppressed edge has no effect: nothing is written and no burst starts.
- R2: The beat counter does not advance on a suppressed edge. After `cke` returns high, the burst continues with the next column, and each read word arrives one cycle later for every suppressed edge.
- R3: In the cycle after a suppressed edge, `rdData` keeps its previous value and `rdValid` is low.
- R4: A READ is registered on edge T0. For `casLat3`=0 the first word is valid when sampled at edge T0+2; for `casLat3`=1 it is valid at edge T0+3. Later words follow on consecutive cycles.
- R5: `blCode` 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. Each READ raises `rdValid` for exactly that many cycles.
- R6: With `interleave`=0 and burst length BL, beat i uses column (start & ~(BL-1)) | ((start+i) mod BL).
- R7: With `interleave`=1, beat i uses column (start & ~(BL-1)) | ((start XOR i) & (BL-1)).
- R8: With `singleWrite`=1, a WRITE stores only the word present on its own edge, at its own column, whatever `blCode` is. Reads still burst at full length.
- R9: With `singleWrite`=0, a WRITE stores the `wrData` of each successive active edge into the successive burst columns.
- R10: A READ or WRITE accepted while a burst is in progress ends that burst. The new burst starts from its own column on the same edge.
- R11: `cmd` encoding: 2'b00 NOP, 2'b01 READ, 2'b10 WRITE, 2'b11 NOP. The array address is {bank, column}. After reset `rdValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable; low suppresses the next internal edge |
| cmd | input | 2 | Command code (NOP, READ, WRITE) |
| bank | input | BANK_W | Bank select |
| col | input | COL_W | Starting column |
| wrData | input | DATA_W | Write word for the current beat |
| blCode | input | 2 | Burst length code (1, 2, 4, 8 beats) |
| interleave | input | 1 | 0 sequential, 1 interleaved order |
| singleWrite | input | 1 | 1 forces writes to a single beat |
| casLat3 | input | 1 | 0 selects latency 2, 1 selects latency 3 |
| rdData | output | DATA_W | Read word |
| rdValid | output | 1 | High when `rdData` carries a new burst word |

## Verification
The bench builds the block with its defaults: 8-bit words, 4 column bits and 1 bank bit, giving a 32-word array. That is small enough for an exhaustive read sweep. It covers every start column in both banks with every burst length, both orderings and both latencies, and the expected columns are computed arithmetically. Directed sequences then cover the rest: suppressed edges inside read and write bursts, commands presented at a suppressed edge, single-write mode, normal write bursts, and a burst cut short by a new command.

// File: rtl/col_burst_pkg.sv
package col_burst_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;    // internal edge active
    logic rdBeat;  // fetch a read word this edge
    logic wrBeat;  // store wrData this edge
  } strobe_t;

  // Burst length code to low-bit column mask (length - 1)
  function automatic logic [2:0] lenMask(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      2'd2:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/col_burst_ctrl.sv
module col_burst_ctrl
  import col_burst_pkg::*;
#(
  parameter int COL_W  = 4,
  parameter int BANK_W = 1,
  localparam int ADDR_W = BANK_W + COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic [1:0]        blCode,
  input  logic              interleave,
  input  logic              singleWrite,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] addr
);

  logic              ckeQ;
  logic              tick;
  logic              active;
  logic [2:0]        beatCnt;
  logic [2:0]        maskQ;
  logic [COL_W-1:0]  startCol;
  logic [BANK_W-1:0] bankQ;
  logic              ilQ;
  logic              wrQ;

  logic              isRd, isWr, accept, beatNow;
  logic [2:0]        newMask;
  logic [COL_W-1:0]  maskW, cntW, burstCol;

  always_comb begin
    tick     = ckeQ;
    isRd     = (cmd == CMD_READ);
    isWr     = (cmd == CMD_WRITE);
    accept   = tick && (isRd || isWr);
    beatNow  = tick && active && !accept;
    newMask  = (isWr && singleWrite) ? 3'd0 : lenMask(blCode);
    maskW    = COL_W'(maskQ);
    cntW     = COL_W'(beatCnt);
    burstCol = (startCol & ~maskW) |
               ((ilQ ? (startCol ^ cntW) : (startCol + cntW)) & maskW);
    addr       = accept ? {bank, col} : {bankQ, burstCol};
    stb.tick   = tick;
    stb.rdBeat = accept ? isRd : (beatNow && !wrQ);
    stb.wrBeat = accept ? isWr : (beatNow && wrQ);
  end

  // Registered enable: one low sample suppresses the following edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ckeQ <= 1'b1;
    else       ckeQ <= cke;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      beatCnt  <= 3'd0;
      maskQ    <= 3'd0;
      startCol <= '0;
      bankQ    <= '0;
      ilQ      <= 1'b0;
      wrQ      <= 1'b0;
    end else if (tick) begin
      if (accept) begin
        active   <= (newMask != 3'd0);
        beatCnt  <= 3'd1;
        maskQ    <= newMask;
        startCol <= col;
        bankQ    <= bank;
        ilQ      <= interleave;
        wrQ      <= isWr;
      end else if (active) begin
        if (beatCnt == maskQ) active  <= 1'b0;
        else                  beatCnt <= beatCnt + 3'd1;
      end
    end
  end

  // R2
  beat_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(beatCnt) && $stable(active) && $stable(startCol)));

  // R5
  beat_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (beatCnt <= maskQ && beatCnt != 3'd0));

  // R8
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isWr && singleWrite) |=> !active);

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && newMask != 3'd0) |=> (active && beatCnt == 3'd1));

endmodule

// File: rtl/col_burst_dp.sv
module col_burst_dp
  import col_burst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              casLat3,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] pipeD [3];
  logic [2:0]        pipeV;
  logic              tickQ;

  always_ff @(posedge clk) begin
    if (stb.wrBeat) mem[addr] <= wrData;
  end

  // Latency pipeline, advanced only on active internal edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) pipeD[i] <= '0;
      pipeV <= '0;
      tickQ <= 1'b0;
    end else begin
      tickQ <= stb.tick;
      if (stb.tick) begin
        pipeD[0] <= mem[addr];
        pipeV[0] <= stb.rdBeat;
        for (int i = 1; i < 3; i++) begin
          pipeD[i] <= pipeD[i-1];
          pipeV[i] <= pipeV[i-1];
        end
      end
    end
  end

  always_comb begin
    rdData  = casLat3 ? pipeD[2] : pipeD[1];
    rdValid = tickQ && (casLat3 ? pipeV[2] : pipeV[1]);
  end

  // R3
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.tick |=> ($stable(rdData) || !$stable(casLat3)));

  // R3
  no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.tick |=> !rdValid);

  // R1
  no_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.tick |-> (!stb.wrBeat && !stb.rdBeat));

endmodule

// File: rtl/col_burst_engine.sv
module col_burst_engine
  import col_burst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COL_W  = 4,
  parameter int BANK_W = 1,
  localparam int ADDR_W = BANK_W + COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        blCode,
  input  logic              interleave,
  input  logic              singleWrite,
  input  logic              casLat3,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  strobe_t           stb;
  logic [ADDR_W-1:0] addr;

  col_burst_ctrl #(.COL_W(COL_W), .BANK_W(BANK_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cke(cke), .cmd(cmd), .bank(bank), .col(col),
    .blCode(blCode), .interleave(interleave), .singleWrite(singleWrite),
    .stb(stb), .addr(addr)
  );

  col_burst_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wrData(wrData),
    .casLat3(casLat3), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/tb_col_burst_engine.sv
`timescale 1ns/1ps
module tb_col_burst_engine;

  localparam int DATA_W = 8;
  localparam int COL_W  = 4;
  localparam int BANK_W = 1;
  localparam int NA     = 1 << (COL_W + BANK_W);
  localparam logic [1:0] NOP = 2'd0, RD = 2'd1, WR = 2'd2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN = 1'b0;
  logic              cke = 1'b1;
  logic [1:0]        cmd = NOP;
  logic [BANK_W-1:0] bank = '0;
  logic [COL_W-1:0]  col = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [1:0]        blCode = '0;
  logic              interleave = 1'b0;
  logic              singleWrite = 1'b1;
  logic              casLat3 = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic              rdValid;

  col_burst_engine #(.DATA_W(DATA_W), .COL_W(COL_W), .BANK_W(BANK_W)) dut (
    .clk(clk), .rstN(rstN), .cke(cke), .cmd(cmd), .bank(bank), .col(col),
    .wrData(wrData), .blCode(blCode), .interleave(interleave),
    .singleWrite(singleWrite), .casLat3(casLat3),
    .rdData(rdData), .rdValid(rdValid)
  );

  int nChecks = 0;
  int nFail   = 0;
  int edgeCnt = 0;
  int lastIssue = 0;
  int sh [NA];
  int seenD[$], seenC[$], allD[$], allV[$], allC[$];

  always @(posedge clk) edgeCnt++;

  always @(negedge clk) begin
    if (rstN) begin
      allD.push_back(int'(rdData));
      allV.push_back(int'(rdValid));
      allC.push_back(edgeCnt);
      if (rdValid) begin
        seenD.push_back(int'(rdData));
        seenC.push_back(edgeCnt);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pat(input int a);
    return (a * 37 + 11) & 8'hFF;
  endfunction

  function automatic int expCol(input int s, input int i, input int bl, input bit il);
    int off;
    off = il ? ((s ^ i) & (bl - 1)) : ((s + i) & (bl - 1));
    return (s & ~(bl - 1)) | off;
  endfunction

  task automatic clearLog();
    seenD.delete(); seenC.delete(); allD.delete(); allV.delete(); allC.delete();
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      cmd = NOP; cke = 1'b1;
    end
  endtask

  task automatic issue(input logic [1:0] c, input int b, input int cl, input int d);
    @(negedge clk);
    cmd = c; bank = BANK_W'(b); col = COL_W'(cl); wrData = DATA_W'(d); cke = 1'b1;
    lastIssue = edgeCnt;
  endtask

  task automatic setMode(input int blc, input bit il, input bit sw, input bit cl3);
    blCode = 2'(blc); interleave = il; singleWrite = sw; casLat3 = cl3;
  endtask

  // Read a burst and compare length, latency and each word
  task automatic readCheck(input int b, input int c, input int blc, input bit il,
                           input bit cl3, input string tag);
    int bl, clv, n, ec;
    bl = 1 << blc; clv = cl3 ? 3 : 2;
    setMode(blc, il, singleWrite, cl3);
    clearLog();
    issue(RD, b, c, 0);
    idle(clv + bl + 2);
    check(seenD.size() == bl, "R5", seenD.size(), bl);
    if (seenD.size() > 0)
      check(seenC[0] == lastIssue + clv, "R4", seenC[0] - lastIssue, clv);
    n = (seenD.size() < bl) ? seenD.size() : bl;
    for (int i = 0; i < n; i++) begin
      ec = expCol(c, i, bl, il);
      check(seenD[i] == sh[b * (1 << COL_W) + ec], tag, seenD[i], sh[b * (1 << COL_W) + ec]);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #1600000;
    check(1'b0, "watchdog", edgeCnt, 0);
    finishRun();
  end

  initial begin
    int first, last, gaps, prev, bb;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    idle(2);
    // R11: reset state
    check(rdValid == 1'b0, "R11", int'(rdValid), 0);

    // R8: fill array with single-beat writes while an 8-beat length is programmed
    setMode(3, 1'b0, 1'b1, 1'b0);
    for (int a = 0; a < NA; a++) begin
      issue(WR, a >> COL_W, a & ((1 << COL_W) - 1), pat(a));
      sh[a] = pat(a);
    end
    idle(2);

    // R6 / R7 / R4 / R5: exhaustive read sweep
    for (int cl3 = 0; cl3 < 2; cl3++)
      for (int blc = 0; blc < 4; blc++)
        for (int il = 0; il < 2; il++)
          for (int a = 0; a < NA; a++)
            readCheck(a >> COL_W, a & ((1 << COL_W) - 1), blc, il[0], cl3[0],
                      il ? "R7" : "R6");

    // R8: later beats of a single-mode write are not stored
    setMode(3, 1'b0, 1'b1, 1'b0);
    issue(WR, 0, 9, 8'h5A);
    sh[9] = 8'h5A;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); cmd = NOP; wrData = 8'hC3;
    end
    idle(2);
    readCheck(0, 8, 3, 1'b0, 1'b0, "R8");

    // R9: normal write burst of 4 from column 6 in bank 1
    setMode(2, 1'b0, 1'b0, 1'b0);
    issue(WR, 1, 6, 8'h10);
    for (int i = 1; i < 4; i++) begin
      @(negedge clk); cmd = NOP; wrData = DATA_W'(8'h10 + i);
    end
    for (int i = 0; i < 4; i++) sh[16 + expCol(6, i, 4, 1'b0)] = 8'h10 + i;
    idle(2);
    readCheck(1, 4, 2, 1'b0, 1'b0, "R9");

    // R2: write burst with one suppressed edge; data at that edge dropped
    setMode(2, 1'b0, 1'b0, 1'b0);
    issue(WR, 0, 0, 8'h21);
    @(negedge clk); cmd = NOP; wrData = 8'h22; cke = 1'b0;
    @(negedge clk); wrData = 8'hEE; cke = 1'b1;
    @(negedge clk); wrData = 8'h23;
    @(negedge clk); wrData = 8'h24;
    sh[0] = 8'h21; sh[1] = 8'h22; sh[2] = 8'h23; sh[3] = 8'h24;
    idle(2);
    readCheck(0, 0, 2, 1'b0, 1'b0, "R2");

    // R1: WRITE at a suppressed edge changes nothing
    setMode(2, 1'b0, 1'b1, 1'b0);
    @(negedge clk); cmd = NOP; cke = 1'b0;
    @(negedge clk); cmd = WR; bank = 1'b1; col = 4'd15; wrData = 8'h99; cke = 1'b1;
    idle(3);
    readCheck(1, 12, 2, 1'b0, 1'b0, "R1");

    // R1: READ at a suppressed edge produces no data
    clearLog();
    @(negedge clk); cmd = NOP; cke = 1'b0;
    @(negedge clk); cmd = RD; bank = 1'b0; col = 4'd0; cke = 1'b1;
    idle(12);
    check(seenD.size() == 0, "R1", seenD.size(), 0);

    // R2 / R3: read burst of 8 with three suppressed edges
    setMode(3, 1'b0, 1'b0, 1'b0);
    clearLog();
    issue(RD, 0, 3, 0);
    @(negedge clk); cmd = NOP; cke = 1'b1;
    @(negedge clk); cke = 1'b0;
    @(negedge clk); cke = 1'b0;
    @(negedge clk); cke = 1'b0;
    idle(14);
    check(seenD.size() == 8, "R2", seenD.size(), 8);
    if (seenD.size() == 8) begin
      first = seenC[0]; last = seenC[7];
      check(last == lastIssue + 2 + 7 + 3, "R2", last - lastIssue, 12);
      for (int i = 0; i < 8; i++)
        check(seenD[i] == sh[expCol(3, i, 8, 1'b0)], "R2", seenD[i], sh[expCol(3, i, 8, 1'b0)]);
      gaps = 0; prev = 0;
      for (int j = 0; j < allC.size(); j++) begin
        if (allC[j] >= first && allC[j] <= last) begin
          if (allV[j] != 0) prev = allD[j];
          else begin
            gaps++;
            check(allD[j] == prev, "R3", allD[j], prev);
          end
        end
      end
      check(gaps == 3, "R3", gaps, 3);
    end

    // R10: second READ two cycles into an 8-beat burst
    setMode(3, 1'b0, 1'b0, 1'b0);
    clearLog();
    issue(RD, 0, 0, 0);
    idle(1);
    issue(RD, 1, 8, 0);
    idle(14);
    check(seenD.size() == 10, "R10", seenD.size(), 10);
    if (seenD.size() == 10) begin
      check(seenC[9] - seenC[0] == 9, "R10", seenC[9] - seenC[0], 9);
      for (int i = 0; i < 10; i++) begin
        bb = (i < 2) ? i : 16 + 8 + (i - 2);
        check(seenD[i] == sh[bb], "R10", seenD[i], sh[bb]);
      end
    end

    finishRun();
  end

endmodule